// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target Model

This block is a synthesizable model of a 1 Kbit serial EEPROM. It sits on a three-wire serial link made of a select line, a serial clock and a data-in line, and it answers on a data-out line that has its own output-enable. A mode input picks the organization: 64 words of 16 bits or 128 words of 8 bits. The serial pins are sampled with a fast system clock. Rising edges of the serial clock are found from the synchronized copies of that clock.

A transfer begins with a start bit. A 2-bit opcode follows, then an address, then write data if the instruction takes any. The block supports these instructions:

- read, with sequential continuation;
- write and erase of one word;
- erase and write of the whole array;
- enable and disable of programming.

Programming instructions take effect after a self-timed cycle whose length is a parameter in system clocks. While that cycle runs, the data-out line can be polled for busy or ready status.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the data-out line is not driven, programming is disabled and every byte of the array reads 0xFF.
- R2: A transfer starts only at the first serial-clock rise with select and data-in both high. Zero bits clocked in with select high before that edge are ignored. Clock activity with select low has no effect.
- R3: After the start bit come 2 opcode bits, then 6 address bits when wide_mode=1 or 7 address bits when wide_mode=0, MSB first, sampled on serial-clock rises. In 16-bit mode, word a holds byte 2a+1 as its high byte and byte 2a as its low byte.
- R4: A read drives 0 on data-out after the last address bit. The word then follows MSB first, one bit per serial-clock rise. With select held high, the next word follows with no extra 0 bit, and the address wraps from the last word to word 0.
- R5: Opcode 10 reads, 01 writes one word and 11 erases one word. Opcode 00 uses the two top address bits: 11 enables programming, 00 disables it, 10 erases the whole array and 01 writes the data to every word.
- R6: While programming is disabled, single-word write, single-word erase, whole-array erase and whole-array write change nothing and start no program cycle.
- R7: An instruction whose bits are not all clocked in before select falls is dropped. A complete programming instruction starts its program cycle when select falls.
- R8: Write stores the data word. Erase sets the word to all ones. Whole-array erase sets every byte to 0xFF. Whole-array write stores the data in every word.
- R9: The program cycle lasts PROG_CYCLES system clocks. Raising select during it drives data-out 0 while busy and 1 once finished. Start bits that arrive while busy are ignored.
- R10: Data-out is driven only for read data and for status. The enable and disable instructions never drive it. It is released within two system clocks after select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_mode | input | 1 | 1 selects 64x16 organization, 0 selects 128x8 |
| chip_sel | input | 1 | Serial select, active high |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_in | input | 1 | Serial data into the device |
| ser_out | output | 1 | Serial data or status out of the device |
| ser_oe | output | 1 | Output-enable for ser_out; low means high-Z |

## Verification
A corrupted opcode or address register shows up at the next read. In that case the wrong word appears, or the 0 bit sits in the wrong place, within one word time of the last address bit. A wrong enable latch or pending-instruction flag shows up as a status response where none should be, or as none where one should be, on the first select rise after the instruction. It also shows up as a changed or unchanged byte on the read sweep that follows. A wrong program counter makes status flip to ready too early or too late against the PROG_CYCLES count. A wrong address increment breaks the long sequential reads at their wrap point.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int MEM_BITS    = 1024,
  parameter int PROG_CYCLES = 5000
) (
  input  logic sys_clk,
  input  logic rst_n,
  input  logic wide_mode,
  input  logic chip_sel,
  input  logic ser_clk,
  input  logic ser_in,
  output logic ser_out,
  output logic ser_oe
);
  localparam int NBYTES = MEM_BITS / 8;
  localparam int AW8    = $clog2(NBYTES);
  localparam int AW16   = AW8 - 1;
  localparam int SW     = (2 + AW8 > 16) ? 2 + AW8 : 16;
  localparam int CW     = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_READ, S_HOLD} st_t;
  typedef enum logic [2:0] {K_NONE, K_WRITE, K_ERASE, K_ERAL, K_WRAL} kind_t;

  logic [7:0] mem [NBYTES];
  logic cs_r, cs_p, sck_r, sck_p, di_r;
  st_t st;
  kind_t p_kind;
  logic [SW-1:0] sh;
  logic [4:0] bcnt, ocnt;
  logic [16:0] osh;
  logic [AW8-1:0] ra, p_addr;
  logic [15:0] p_data;
  logic wen, armed, busy, stat_on;
  logic [CW-1:0] cnt;

  wire rise    = sck_r & ~sck_p;
  wire cs_fall = cs_p & ~cs_r;
  wire cs_rise = cs_r & ~cs_p;
  wire [SW-1:0] nsh = {sh[SW-2:0], di_r};
  wire commit = busy && (cnt == CW'(1));

  logic [1:0] opc, sub;
  logic [AW8-1:0] adr, ra_nxt;
  logic [15:0] w_hdr, w_nxt, wdata;
  logic hdr_last, data_last;

  always_comb begin
    if (wide_mode) begin
      opc    = nsh[AW16+1:AW16];
      sub    = nsh[AW16-1:AW16-2];
      adr    = {1'b0, nsh[AW16-1:0]};
      ra_nxt = {1'b0, ra[AW16-1:0] + 1'b1};
      w_hdr  = {mem[{adr[AW16-1:0], 1'b1}], mem[{adr[AW16-1:0], 1'b0}]};
      w_nxt  = {mem[{ra_nxt[AW16-1:0], 1'b1}], mem[{ra_nxt[AW16-1:0], 1'b0}]};
      wdata  = nsh[15:0];
    end else begin
      opc    = nsh[AW8+1:AW8];
      sub    = nsh[AW8-1:AW8-2];
      adr    = nsh[AW8-1:0];
      ra_nxt = ra + 1'b1;
      w_hdr  = {8'h00, mem[adr]};
      w_nxt  = {8'h00, mem[ra_nxt]};
      wdata  = {8'h00, nsh[7:0]};
    end
  end

  assign hdr_last  = bcnt == (wide_mode ? 5'(AW16 + 1) : 5'(AW8 + 1));
  assign data_last = bcnt == (wide_mode ? 5'd15 : 5'd7);
  assign ser_out   = stat_on ? ~busy : osh[16];
  assign ser_oe    = stat_on | (st == S_READ);

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_r <= 1'b0; cs_p <= 1'b0; sck_r <= 1'b0; sck_p <= 1'b0; di_r <= 1'b0;
    end else begin
      cs_r <= chip_sel; cs_p <= cs_r; sck_r <= ser_clk; sck_p <= sck_r; di_r <= ser_in;
    end
  end

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; p_kind <= K_NONE; sh <= '0; bcnt <= '0; ocnt <= '0;
      osh <= '0; ra <= '0; p_addr <= '0; p_data <= '0;
      wen <= 1'b0; armed <= 1'b0; busy <= 1'b0; stat_on <= 1'b0; cnt <= '0;
    end else begin
      if (busy) begin
        cnt <= cnt - CW'(1);
        if (commit) busy <= 1'b0;
      end
      if (cs_fall) begin
        st <= S_IDLE;
        stat_on <= 1'b0;
        armed <= 1'b0;
        if (armed && wen) begin
          busy <= 1'b1;
          cnt  <= CW'(PROG_CYCLES);
        end
      end else begin
        if (cs_rise && busy) stat_on <= 1'b1;
        if (rise) begin
          case (st)
            S_IDLE: if (cs_r && di_r && !busy) begin
              st <= S_CMD; bcnt <= '0; sh <= '0; stat_on <= 1'b0;
            end
            S_CMD: begin
              sh <= nsh;
              bcnt <= bcnt + 5'd1;
              if (hdr_last) begin
                p_addr <= adr;
                bcnt <= '0;
                st <= S_HOLD;
                case (opc)
                  2'b10: begin
                    st <= S_READ;
                    ra <= adr;
                    osh <= wide_mode ? {1'b0, w_hdr} : {1'b0, w_hdr[7:0], 8'h00};
                    ocnt <= wide_mode ? 5'd16 : 5'd8;
                  end
                  2'b01: begin p_kind <= K_WRITE; st <= S_DATA; end
                  2'b11: begin p_kind <= K_ERASE; armed <= 1'b1; end
                  default: case (sub)
                    2'b11: wen <= 1'b1;
                    2'b00: wen <= 1'b0;
                    2'b10: begin p_kind <= K_ERAL; armed <= 1'b1; end
                    default: begin p_kind <= K_WRAL; st <= S_DATA; end
                  endcase
                endcase
              end
            end
            S_DATA: begin
              sh <= nsh;
              bcnt <= bcnt + 5'd1;
              if (data_last) begin
                p_data <= wdata; armed <= 1'b1; st <= S_HOLD;
              end
            end
            S_READ: begin
              if (ocnt != 5'd0) begin
                osh <= osh << 1;
                ocnt <= ocnt - 5'd1;
              end else begin
                ra <= ra_nxt;
                osh <= wide_mode ? {w_nxt, 1'b0} : {w_nxt[7:0], 9'h000};
                ocnt <= wide_mode ? 5'd15 : 5'd7;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      case (p_kind)
        K_WRITE, K_ERASE: begin
          if (p_kind == K_WRITE && !wide_mode) mem[p_addr] <= p_data[7:0];
          else if (p_kind == K_ERASE && !wide_mode) mem[p_addr] <= 8'hFF;
          else begin
            mem[{p_addr[AW16-1:0], 1'b0}] <= (p_kind == K_WRITE) ? p_data[7:0]  : 8'hFF;
            mem[{p_addr[AW16-1:0], 1'b1}] <= (p_kind == K_WRITE) ? p_data[15:8] : 8'hFF;
          end
        end
        K_ERAL: for (int i = 0; i < NBYTES; i++) mem[i] <= 8'hFF;
        K_WRAL: for (int i = 0; i < NBYTES; i++)
          mem[i] <= (wide_mode && i[0]) ? p_data[15:8] : p_data[7:0];
        default: ;
      endcase
    end
  end

  AST_HIZ_CS_LOW: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (!cs_r && !cs_p) |-> !ser_oe); // R10
  AST_PROG_NEEDS_WEN: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(busy) |-> wen); // R6
  AST_BUSY_IGNORES_START: assert property (@(posedge sys_clk) disable iff (!rst_n)
    busy |-> (st == S_IDLE)); // R9
  AST_PROG_ENDS: assert property (@(posedge sys_clk) disable iff (!rst_n)
    commit |=> !busy); // R9
  AST_READ_NEEDS_SEL: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (st == S_READ) |-> cs_p); // R4
endmodule

// File: tb/mw_eeprom_tb_top.sv
`timescale 1ns/1ps
module mw_eeprom_tb_top;
  localparam int PROG = 100;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wide = 1'b0, cs = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic lo, loe;
  logic [7:0] refm [128];
  bit wen_m;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  mw_eeprom #(.MEM_BITS(1024), .PROG_CYCLES(PROG)) dut_i (
    .sys_clk(clk), .rst_n(rst_n), .wide_mode(wide), .chip_sel(cs),
    .ser_clk(sck), .ser_in(sdi), .ser_out(sdo), .ser_oe(sdo_oe));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    @(negedge clk); sdi = b;
    repeat (2) @(negedge clk); sck = 1'b1;
    repeat (4) @(negedge clk); lo = sdo; loe = sdo_oe; sck = 1'b0;
  endtask

  task automatic send(input int n, input logic [31:0] v);
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
  endtask

  task automatic sel_on;
    @(negedge clk); cs = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sel_off;
    @(negedge clk); cs = 1'b0;
    repeat (3) @(negedge clk);
    chk(sdo_oe === 1'b0, "R10 release after select low", sdo_oe, 0);
  endtask

  task automatic instr(input logic w, input logic [1:0] op, input logic [6:0] a);
    wide = w;
    send(1, 1); send(2, op);
    if (w) send(6, a[5:0]); else send(7, a);
  endtask

  task automatic special(input logic w, input logic [1:0] sub);
    instr(w, 2'b00, w ? {1'b0, sub, 4'b0} : {sub, 5'b0});
  endtask

  task automatic settle;
    repeat (PROG + 10) @(negedge clk);
  endtask

  task automatic prog8(input int a, input logic [7:0] d);
    sel_on; instr(0, 2'b01, a[6:0]); send(8, d); sel_off; settle;
    if (wen_m) refm[a] = d;
  endtask

  task automatic prog16(input int a, input logic [15:0] d);
    sel_on; instr(1, 2'b01, a[6:0]); send(16, d); sel_off; settle;
    if (wen_m) begin refm[2*a] = d[7:0]; refm[2*a+1] = d[15:8]; end
  endtask

  task automatic erase(input logic w, input int a);
    sel_on; instr(w, 2'b11, a[6:0]); sel_off; settle;
    if (wen_m) begin
      if (w) begin refm[2*a] = 8'hFF; refm[2*a+1] = 8'hFF; end
      else refm[a] = 8'hFF;
    end
  endtask

  task automatic rd_check(input logic w, input int a, input int count, input string req);
    logic [15:0] word, exp;
    int dw, n, idx;
    dw = w ? 16 : 8; n = w ? 64 : 128;
    sel_on; instr(w, 2'b10, a[6:0]);
    chk(loe === 1'b1 && lo === 1'b0, "R4 dummy zero", {loe, lo}, 2'b10);
    for (int k = 0; k < count; k++) begin
      word = '0;
      for (int b = 0; b < dw; b++) begin sbit(1'b0); word = {word[14:0], lo}; end
      idx = (a + k) % n;
      exp = w ? {refm[2*idx+1], refm[2*idx]} : {8'h00, refm[idx]};
      chk(word === exp, req, word, exp);
    end
    sel_off;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] tmp;
    for (int i = 0; i < 128; i++) refm[i] = 8'hFF;
    wen_m = 0;
    repeat (5) @(negedge clk);
    chk(sdo_oe === 1'b0, "R1 not driven at reset", sdo_oe, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdo_oe === 1'b0, "R1 not driven after reset", sdo_oe, 0);
    rd_check(0, 0, 4, "R1 erased after reset");

    // R6: programming disabled at reset
    prog8(5, 8'h3C);
    sel_on; chk(sdo_oe === 1'b0, "R6 no program cycle while disabled", sdo_oe, 0); sel_off;
    rd_check(0, 5, 1, "R6 write ignored while disabled");

    // R5/R10: enable never drives data-out
    sel_on; special(0, 2'b11);
    chk(loe === 1'b0, "R10 enable does not drive", loe, 0);
    sel_off; wen_m = 1;

    // R3/R8: x8 sweep, then long sequential read with wrap
    for (int a = 0; a < 128; a++) prog8(a, 8'((a * 37 + 11) & 255));
    rd_check(0, 0, 129, "R4 x8 sequential with wrap");
    rd_check(1, 60, 6, "R3 x16 byte mapping with wrap");

    // x16 sweep
    for (int a = 0; a < 64; a++) begin
      tmp = 16'(a * 1031) ^ 16'hA5C3;
      prog16(a, tmp);
    end
    rd_check(1, 0, 64, "R8 x16 write sweep");
    rd_check(0, 0, 128, "R3 x16 words seen as bytes");

    // R8: single erases
    erase(1, 5); erase(0, 100);
    rd_check(1, 4, 3, "R8 x16 erase");
    rd_check(0, 99, 3, "R8 x8 erase");

    // R9: status polling, start ignored while busy
    sel_on; instr(0, 2'b01, 7'd3); send(8, 8'hC7); sel_off; refm[3] = 8'hC7;
    sel_on;
    chk(sdo_oe === 1'b1 && sdo === 1'b0, "R9 busy status", {sdo_oe, sdo}, 2'b10);
    instr(0, 2'b10, 7'd3);
    chk(loe === 1'b1 && lo === 1'b0, "R9 start ignored while busy", {loe, lo}, 2'b10);
    repeat (PROG) @(negedge clk);
    chk(sdo_oe === 1'b1 && sdo === 1'b1, "R9 ready status", {sdo_oe, sdo}, 2'b11);
    sel_off;
    rd_check(0, 3, 1, "R9 programmed after cycle");

    // R7: aborted instruction
    sel_on; instr(0, 2'b01, 7'd9); send(4, 4'hA); sel_off;
    sel_on; chk(sdo_oe === 1'b0, "R7 aborted write starts no cycle", sdo_oe, 0); sel_off;
    rd_check(0, 9, 1, "R7 aborted write leaves data");

    // R2: leading zeros, and clocks with select low
    sel_on; send(3, 0); instr(0, 2'b10, 7'd10);
    chk(loe === 1'b1 && lo === 1'b0, "R2 start after leading zeros", {loe, lo}, 2'b10);
    tmp = '0;
    for (int b = 0; b < 8; b++) begin sbit(1'b0); tmp = {tmp[14:0], lo}; end
    chk(tmp[7:0] === refm[10], "R2 read after leading zeros", tmp[7:0], refm[10]);
    sel_off;
    instr(0, 2'b01, 7'd20); send(8, 8'h00);
    chk(sdo_oe === 1'b0, "R2 select low no drive", sdo_oe, 0);
    sel_on; chk(sdo_oe === 1'b0, "R2 select low no program", sdo_oe, 0); sel_off;
    rd_check(0, 20, 1, "R2 select low no change");

    // R8/R5: whole-array write and erase
    sel_on; special(1, 2'b01); send(16, 16'h1234); sel_off; settle;
    for (int i = 0; i < 128; i++) refm[i] = i[0] ? 8'h12 : 8'h34;
    rd_check(0, 0, 128, "R8 x16 whole-array write");
    sel_on; special(1, 2'b10); sel_off; settle;
    for (int i = 0; i < 128; i++) refm[i] = 8'hFF;
    rd_check(1, 0, 64, "R8 whole-array erase");
    sel_on; special(0, 2'b01); send(8, 8'h5A); sel_off; settle;
    for (int i = 0; i < 128; i++) refm[i] = 8'h5A;
    rd_check(0, 0, 128, "R8 x8 whole-array write");

    // R6: disable then programming ignored
    sel_on; special(1, 2'b00);
    chk(loe === 1'b0, "R10 disable does not drive", loe, 0);
    sel_off; wen_m = 0;
    prog16(7, 16'h0F0F);
    erase(0, 30);
    sel_on; special(0, 2'b10); sel_off; settle;
    sel_on; chk(sdo_oe === 1'b0, "R6 no cycle after disable", sdo_oe, 0); sel_off;
    rd_check(1, 0, 64, "R6 programming ignored after disable");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule